// File: doc/BRIEF.md
# Banked PWM Channel Register File

This block is the byte-wide host register front end for a group of independent PWM channels. Each channel owns a set of control bytes, but the host sees only one shared window of control addresses. A bank-select register chooses which channel's copy that window reaches, for both reads and writes. A bank-enable mask sits beside the window and holds one enable bit per channel. Software turns a single channel on or off by reading the mask, changing one bit and writing it back.

All channel copies are held in flops and driven out in parallel, both as raw bytes and as decoded fields. The PWM and ramp engines downstream use these values directly. Two further registers form the write port of a shared duty lookup table. Writing the upper byte issues either a one-cycle table write strobe or a one-cycle read request, with the index and the nine-bit duty value held beside it.

The register map starts at parameter `BASE`. Offsets 0 to 6 are the control window, offset 7 is bank select and offset 8 is the enable mask. Offset 9 holds the low table byte and offset 10 the high table byte.

Top module: `pwm_bank_regs`

## Requirements
- R1: After reset every register reads zero, bank 0 is selected and every output is zero.
- R2: A write to window offset r (0..6) changes only control byte r of the selected channel. A read of offset r returns that byte of the selected channel.
- R3: Writing a value below the channel count to offset 7 selects that channel, and offset 7 reads it back. Writing a value of 8 or more is ignored.
- R4: Offset 8 holds the enable mask, with bit n enabling channel n. It drives `chan_en` and reads back as written.
- R5: `chan_active[n]` is high exactly when enable bit n is set and control byte 0 of channel n has bit 3 (output enable) and bit 2 (PWM enable) both set.
- R6: Decoded fields per channel: `step_code` is byte0[7:4], `clk_sel` is byte4[6:5], `prediv` is byte4[4:3], `expo` is byte4[2:0] and `size9` is byte5[0]. When `size9` is 1, `pwm_val` is {byte4[7], byte3}. Otherwise it is byte3[5:0] zero-extended. `cfg_flat` carries byte r of channel n at bits [(n*7+r)*8 +: 8].
- R7: A write to offset 10 with bit 6 clear raises `lut_we` for exactly the next cycle. In that cycle `lut_idx` = written bits 5:0 and `lut_data` = {written bit 7, offset 9 byte}.
- R8: A write to offset 10 with bit 6 set raises `lut_rd` for exactly the next cycle, with the same index, and does not raise `lut_we`.
- R9: Reads of addresses outside BASE..BASE+10 return zero. Writes to them change no register and raise no strobe.
- R10: `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read enable for `rdata` |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| bank_sel | output | $clog2(NCH) | Selected channel |
| chan_en | output | NCH | Per-channel enable mask |
| chan_active | output | NCH | Enabled with output and PWM enables set |
| cfg_flat | output | NCH*7*8 | All control bytes of all channels |
| step_code | output | NCH*4 | Ramp step duration code per channel |
| clk_sel | output | NCH*2 | Clock select per channel |
| prediv | output | NCH*2 | Pre-divider code per channel |
| expo | output | NCH*3 | Divider exponent per channel |
| size9 | output | NCH | 9-bit size select per channel |
| pwm_val | output | NCH*9 | Direct duty value per channel |
| lut_we | output | 1 | Table write strobe |
| lut_rd | output | 1 | Table read request |
| lut_idx | output | 6 | Table index |
| lut_data | output | 9 | Table duty value |

## Verification
Every channel is selected in turn and loaded with a distinct byte pattern derived from the channel and offset. All channels are then read back, so a write that lands in the wrong bank or offset fails on the readback. The same patterns toggle byte 0 bits 3:2, byte 5 bit 0 and byte 4 bit 7 across channels. Together with a sweep of enable masks, this separates the size-dependent duty decode and the three-way gating of `chan_active`. Bank-select values from 8 to 15 and 255 show that out-of-range selects are dropped. A full address sweep covers the unmapped space. Table writes and read requests are alternated to tell the two strobes and their one-cycle width apart.

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs #(
  parameter int NCH = 8,
  parameter int NCTL = 7,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [$clog2(NCH)-1:0] bank_sel,
  output logic [NCH-1:0]       chan_en,
  output logic [NCH-1:0]       chan_active,
  output logic [NCH*NCTL*8-1:0] cfg_flat,
  output logic [NCH*4-1:0]     step_code,
  output logic [NCH*2-1:0]     clk_sel,
  output logic [NCH*2-1:0]     prediv,
  output logic [NCH*3-1:0]     expo,
  output logic [NCH-1:0]       size9,
  output logic [NCH*9-1:0]     pwm_val,
  output logic                 lut_we,
  output logic                 lut_rd,
  output logic [5:0]           lut_idx,
  output logic [8:0]           lut_data
);
  localparam int SW = $clog2(NCH);
  localparam int RW = $clog2(NCTL);
  localparam int OFF_SEL = NCTL;
  localparam int OFF_EN = NCTL + 1;
  localparam int OFF_TLO = NCTL + 2;
  localparam int OFF_THI = NCTL + 3;
  localparam int NREG = NCTL + 4;
  localparam logic [AW-1:0] A_SEL = BASE + AW'(OFF_SEL);
  localparam logic [AW-1:0] A_EN = BASE + AW'(OFF_EN);
  localparam logic [AW-1:0] A_TLO = BASE + AW'(OFF_TLO);
  localparam logic [AW-1:0] A_THI = BASE + AW'(OFF_THI);

  logic [7:0] ctl_q [NCH][NCTL];
  logic [SW-1:0] sel_q;
  logic [NCH-1:0] en_q;
  logic [7:0] tlo_q, thi_q;

  logic [AW-1:0] off;
  logic hit, ctl_hit;
  logic [RW-1:0] ridx;

  assign off = addr - BASE;
  assign hit = (addr >= BASE) && (off < AW'(NREG));
  assign ctl_hit = hit && (off < AW'(NCTL));
  assign ridx = off[RW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NCTL; r++)
          ctl_q[c][r] <= '0;
    end else if (wr_en && ctl_hit) begin
      ctl_q[sel_q][ridx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q <= '0;
      tlo_q <= '0;
      thi_q <= '0;
      lut_we <= 1'b0;
      lut_rd <= 1'b0;
      lut_idx <= '0;
      lut_data <= '0;
    end else begin
      lut_we <= 1'b0;
      lut_rd <= 1'b0;
      if (wr_en && addr == A_SEL && wdata < 8'(NCH)) sel_q <= wdata[SW-1:0];
      if (wr_en && addr == A_EN) en_q <= wdata[NCH-1:0];
      if (wr_en && addr == A_TLO) tlo_q <= wdata;
      if (wr_en && addr == A_THI) begin
        thi_q <= wdata;
        lut_we <= ~wdata[6];
        lut_rd <= wdata[6];
        lut_idx <= wdata[5:0];
        lut_data <= {wdata[7], tlo_q};
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      if (ctl_hit) rdata = ctl_q[sel_q][ridx];
      else if (addr == A_SEL) rdata = 8'(sel_q);
      else if (addr == A_EN) rdata = 8'(en_q);
      else if (addr == A_TLO) rdata = tlo_q;
      else rdata = thi_q;
    end
  end

  assign bank_sel = sel_q;
  assign chan_en = en_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    for (genvar r = 0; r < NCTL; r++) begin : g_byte
      assign cfg_flat[(g*NCTL+r)*8 +: 8] = ctl_q[g][r];
    end
    assign chan_active[g] = en_q[g] & ctl_q[g][0][3] & ctl_q[g][0][2];
    assign step_code[g*4 +: 4] = ctl_q[g][0][7:4];
    assign clk_sel[g*2 +: 2] = ctl_q[g][4][6:5];
    assign prediv[g*2 +: 2] = ctl_q[g][4][4:3];
    assign expo[g*3 +: 3] = ctl_q[g][4][2:0];
    assign size9[g] = ctl_q[g][5][0];
    assign pwm_val[g*9 +: 9] = ctl_q[g][5][0] ? {ctl_q[g][4][7], ctl_q[g][3]}
                                               : {3'b000, ctl_q[g][3][5:0]};
  end

  a_r3_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEL && wdata >= 8'(NCH)) |=> $stable(bank_sel));
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_EN) |=> $stable(chan_en));
  a_r2_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ctl_hit) |=> $stable(cfg_flat));
  a_r7_we_source: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> $past(wr_en && addr == A_THI && !wdata[6]));
  a_r8_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lut_we, lut_rd}));
  a_r9_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> !(lut_we || lut_rd));
endmodule

// File: tb/pwm_bank_regs_bench.sv
module pwm_bank_regs_bench;
  localparam int NCH = 8;
  localparam int NCTL = 7;
  localparam logic [7:0] BASE = 8'h40;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic [2:0] bank_sel;
  logic [NCH-1:0] chan_en, chan_active, size9;
  logic [NCH*NCTL*8-1:0] cfg_flat;
  logic [NCH*4-1:0] step_code;
  logic [NCH*2-1:0] clk_sel, prediv;
  logic [NCH*3-1:0] expo;
  logic [NCH*9-1:0] pwm_val;
  logic lut_we, lut_rd;
  logic [5:0] lut_idx;
  logic [8:0] lut_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_bank_regs #(.NCH(NCH), .NCTL(NCTL), .AW(8), .BASE(BASE)) u_pwm_bank_regs (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .bank_sel, .chan_en,
    .chan_active, .cfg_flat, .step_code, .clk_sel, .prediv, .expo, .size9,
    .pwm_val, .lut_we, .lut_rd, .lut_idx, .lut_data);

  function automatic logic [7:0] pat(int c, int r);
    return 8'((c * 37 + r * 11 + 5) % 256);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; rd_en = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rdchk(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1; wr_en = 0;
    #1;
    chk(tag, 64'(rdata), 64'(exp));
    rd_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] mask;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int o = 0; o < 11; o++) rdchk(BASE + 8'(o), 8'h00, "R1");
    chk("R1", 64'({bank_sel, chan_en, chan_active, lut_we, lut_rd}), 64'd0);
    chk("R1", 64'(|cfg_flat), 64'd0);

    // R2 fill every bank through the window
    for (int c = 0; c < NCH; c++) begin
      wr(BASE + 8'd7, 8'(c));
      for (int r = 0; r < NCTL; r++) wr(BASE + 8'(r), pat(c, r));
    end
    for (int c = 0; c < NCH; c++) begin
      wr(BASE + 8'd7, 8'(c));
      rdchk(BASE + 8'd7, 8'(c), "R3");
      for (int r = 0; r < NCTL; r++) rdchk(BASE + 8'(r), pat(c, r), "R2");
    end
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NCTL; r++)
        chk("R6", 64'(cfg_flat[(c*NCTL+r)*8 +: 8]), 64'(pat(c, r)));

    // R6 decoded fields
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b0, b3, b4, b5;
      logic [8:0] pv;
      b0 = pat(c, 0); b3 = pat(c, 3); b4 = pat(c, 4); b5 = pat(c, 5);
      pv = b5[0] ? {b4[7], b3} : {3'b000, b3[5:0]};
      chk("R6", 64'(step_code[c*4 +: 4]), 64'(b0 >> 4));
      chk("R6", 64'(clk_sel[c*2 +: 2]), 64'((b4 >> 5) % 4));
      chk("R6", 64'(prediv[c*2 +: 2]), 64'((b4 >> 3) % 4));
      chk("R6", 64'(expo[c*3 +: 3]), 64'(b4 % 8));
      chk("R6", 64'(size9[c]), 64'(b5 % 2));
      chk("R6", 64'(pwm_val[c*9 +: 9]), 64'(pv));
    end

    // R4 / R5 enable mask sweep
    foreach (mask[i]) mask[i] = 0;
    for (int m = 0; m < 256; m += 37) begin
      mask = 8'(m);
      wr(BASE + 8'd8, mask);
      rdchk(BASE + 8'd8, mask, "R4");
      chk("R4", 64'(chan_en), 64'(mask));
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] b0;
        b0 = pat(c, 0);
        chk("R5", 64'(chan_active[c]), 64'(mask[c] & b0[3] & b0[2]));
      end
    end
    wr(BASE + 8'd8, 8'hFF);
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b0;
      b0 = pat(c, 0);
      chk("R5", 64'(chan_active[c]), 64'(b0[3] & b0[2]));
    end

    // R3 out-of-range bank select ignored
    wr(BASE + 8'd7, 8'd5);
    for (int v = 8; v < 16; v++) begin
      wr(BASE + 8'd7, 8'(v));
      rdchk(BASE + 8'd7, 8'd5, "R3");
    end
    wr(BASE + 8'd7, 8'hFF);
    chk("R3", 64'(bank_sel), 64'd5);
    rdchk(BASE + 8'd2, pat(5, 2), "R3");

    // R7 / R8 table port
    wr(BASE + 8'd9, 8'hA5);
    wr(BASE + 8'd10, 8'h80 | 8'd17);
    #1;
    chk("R7", 64'({lut_we, lut_rd}), 64'b10);
    chk("R7", 64'(lut_idx), 64'd17);
    chk("R7", 64'(lut_data), 64'h1A5);
    @(negedge clk); #1;
    chk("R7", 64'(lut_we), 64'd0);
    wr(BASE + 8'd9, 8'h3C);
    wr(BASE + 8'd10, 8'd42);
    #1;
    chk("R7", 64'(lut_data), 64'h03C);
    chk("R7", 64'(lut_idx), 64'd42);
    wr(BASE + 8'd10, 8'h40 | 8'd9);
    #1;
    chk("R8", 64'({lut_we, lut_rd}), 64'b01);
    chk("R8", 64'(lut_idx), 64'd9);
    @(negedge clk); #1;
    chk("R8", 64'(lut_rd), 64'd0);
    rdchk(BASE + 8'd9, 8'h3C, "R7");
    rdchk(BASE + 8'd10, 8'h49, "R8");

    // R9 unmapped space
    for (int a = 0; a < 256; a++)
      if (a < 32'(BASE) || a > 32'(BASE) + 10) rdchk(8'(a), 8'h00, "R9");
    wr(8'h3F, 8'hFF);
    #1; chk("R9", 64'({lut_we, lut_rd}), 64'd0);
    wr(BASE + 8'd11, 8'h00);
    wr(8'hFF, 8'h40);
    #1; chk("R9", 64'({lut_we, lut_rd}), 64'd0);
    rdchk(BASE + 8'd7, 8'd5, "R9");
    rdchk(BASE + 8'd8, 8'hFF, "R9");
    rdchk(BASE + 8'd9, 8'h3C, "R9");
    rdchk(BASE + 8'd10, 8'h49, "R9");
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NCTL; r++)
        chk("R9", 64'(cfg_flat[(c*NCTL+r)*8 +: 8]), 64'(pat(c, r)));

    // R10 no read enable
    @(negedge clk);
    addr = BASE + 8'd8; rd_en = 0; #1;
    chk("R10", 64'(rdata), 64'd0);
    addr = BASE + 8'd1; #1;
    chk("R10", 64'(rdata), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule